// File: doc/BRIEF.md
# Two-Bank Line Replay Deinterlacer

This block turns a stream of interlaced video lines into a progressive stream by holding one line in on-chip storage and replaying it twice. Two storage banks take turns: the incoming line fills one bank while the line captured before it is read back from the other bank, and the two banks exchange roles at every line-start pulse. Luma and the two chroma components sit in their own memories, so all three are stored and replayed in parallel.

Input and output share one 27 MHz clock. Incoming samples arrive on a write strobe that is high on about every second cycle, which gives a 13.5 MHz fill rate. The read side steps one address per clock. An incoming line period of 1716 clocks therefore holds two full replays of a 720-sample line, so each captured line becomes two consecutive output display lines.

Top module: `line_doubler`

## Requirements
- R1: While reset is high and after it is released, `rd_valid`, `rd_line_start` and `replay_done` are low until a line holding the full line length (720 samples) has been closed by a `line_start` pulse.
- R2: Each `wr_en` cycle stores the Y, Cb and Cr inputs at the next address of the bank being filled, starting at address 0; strobes after the 720th sample of a line are discarded and do not appear in the replay.
- R3: Banks exchange roles only on `line_start`; the fill address restarts at 0, and a `wr_en` given in the same cycle as `line_start` is discarded.
- R4: When `line_start` is sampled at clock edge k and the line just closed holds 720 samples, `rd_valid` goes high after edge k+1 and stays high for 1440 consecutive cycles.
- R5: The replay presents samples 0 to 719 of the closed line in order, one per clock, and then presents the same 720 samples in the same order a second time.
- R6: `rd_line_start` is high exactly with sample 0 of the first pass and sample 0 of the second pass.
- R7: `replay_done` rises in the cycle that shows the last sample of the second pass, `rd_valid` falls the next cycle, and `replay_done` stays high until the next `line_start`, which clears it.
- R8: When `line_start` closes a line that holds fewer than 720 samples, no replay starts and `rd_valid` stays low.
- R9: Filling the write bank while a replay is in progress does not change any replayed sample.
- R10: A `line_start` arriving during a replay ends that replay: the cycle after edge k still shows the old replay's next sample, and from edge k+1 on the outputs follow the rules of R4 and R8 for the newly closed line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz clock shared by fill and replay |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Sample strobe for the incoming line |
| line_start | input | 1 | Pulse marking the start of a new incoming line; swaps the banks |
| y_in | input | DW | Incoming luma sample |
| cb_in | input | DW | Incoming blue-difference sample |
| cr_in | input | DW | Incoming red-difference sample |
| rd_valid | output | 1 | Replayed sample present on the outputs |
| rd_line_start | output | 1 | Marks the first sample of each output display line |
| y_out | output | DW | Replayed luma sample |
| cb_out | output | DW | Replayed blue-difference sample |
| cr_out | output | DW | Replayed red-difference sample |
| replay_done | output | 1 | Both passes of the current line have been shown |

## Verification
The embedded properties watch, on every clock, that the fill address never runs past the line length and restarts on a swap, that the read address steps by one during a replay, that an incomplete line never starts one, that the done flag excludes and then outlasts a replay, and that an active read always yields a valid output one cycle later. The sample values themselves, the double ordering, the line-start marks, the discard of surplus and coinciding strobes, the independence of fill and replay, and an early swap cutting a replay short can only be shown by the bench's scenarios, which compare every output against a queue of expected samples built from the written lines.

// File: rtl/lb_pkg.sv
package lb_pkg;

    // Which of the two line stores a side is using.
    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    // Number of separately stored colour components.
    localparam int NCOMP  = 3;
    localparam int C_Y    = 0;
    localparam int C_CB   = 1;
    localparam int C_CR   = 2;
    localparam int NBANKS = 2;

    // Replay sequencer state.
    typedef struct packed {
        logic active;   // reading a stored line
        logic second;   // in the second pass
        logic done;     // both passes shown
    } replay_t;

    function automatic bank_e other_bank(input bank_e b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction

endpackage

// File: rtl/lb_bank_ram.sv
module lb_bank_ram #(
    parameter int W     = 8,
    parameter int DEPTH = 720,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/lb_wr_ctrl.sv
module lb_wr_ctrl
    import lb_pkg::*;
#(
    parameter int LINE_LEN = 720,
    parameter int AW       = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          line_start,
    output bank_e         wr_bank,
    output logic [AW-1:0] wr_addr,
    output logic          wr_fire,
    output logic          line_full
);

    localparam logic [AW-1:0] FULL_CNT = AW'(LINE_LEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bank <= BANK_A;
            wr_addr <= '0;
        end else if (line_start) begin
            wr_bank <= other_bank(wr_bank);
            wr_addr <= '0;
        end else if (wr_en && (wr_addr != FULL_CNT)) begin
            wr_addr <= wr_addr + 1'b1;
        end
    end

    // Strobes on a swap cycle or past the line end are dropped.
    assign wr_fire   = wr_en && !line_start && (wr_addr != FULL_CNT);
    assign line_full = (wr_addr == FULL_CNT);

    p_fill_bound_r2: assert property (@(posedge clk) disable iff (rst)
        wr_addr <= FULL_CNT);

    p_swap_restart_r3: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (wr_addr == '0) && (wr_bank != $past(wr_bank)));

    p_no_swap_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !line_start |=> (wr_bank == $past(wr_bank)));

endmodule

// File: rtl/lb_rd_ctrl.sv
module lb_rd_ctrl
    import lb_pkg::*;
#(
    parameter int LINE_LEN = 720,
    parameter int AW       = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          swap,
    input  logic          line_full,
    output logic [AW-1:0] rd_addr,
    output logic          rd_active,
    output logic          rd_first,
    output logic          replay_done
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(LINE_LEN - 1);

    replay_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            rd_addr <= '0;
        end else if (swap) begin
            st.active <= line_full;
            st.second <= 1'b0;
            st.done   <= 1'b0;
            rd_addr   <= '0;
        end else if (st.active) begin
            if (rd_addr == LAST_ADDR) begin
                rd_addr <= '0;
                if (st.second) begin
                    st.active <= 1'b0;
                    st.done   <= 1'b1;
                end else begin
                    st.second <= 1'b1;
                end
            end else begin
                rd_addr <= rd_addr + 1'b1;
            end
        end
    end

    assign rd_active   = st.active;
    assign rd_first    = st.active && (rd_addr == '0);
    assign replay_done = st.done;

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        replay_done |-> !rd_active);

    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (replay_done && !swap) |=> replay_done);

    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_active && !swap && (rd_addr != LAST_ADDR)) |=>
            (rd_addr == AW'($past(rd_addr) + 1'b1)));

    p_short_line_r8: assert property (@(posedge clk) disable iff (rst)
        (swap && !line_full) |=> !rd_active);

endmodule

// File: rtl/line_doubler.sv
module line_doubler
    import lb_pkg::*;
#(
    parameter int DW       = 8,
    parameter int LINE_LEN = 720
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          line_start,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] cb_in,
    input  logic [DW-1:0] cr_in,
    output logic          rd_valid,
    output logic          rd_line_start,
    output logic [DW-1:0] y_out,
    output logic [DW-1:0] cb_out,
    output logic [DW-1:0] cr_out,
    output logic          replay_done
);

    localparam int AW = $clog2(LINE_LEN + 1);

    bank_e         wr_bank;
    logic [AW-1:0] wr_addr;
    logic          wr_fire;
    logic          line_full;
    logic [AW-1:0] rd_addr;
    logic          rd_active;
    logic          rd_first;

    logic [DW-1:0] comp_in [NCOMP];
    logic [DW-1:0] bank_q  [NBANKS][NCOMP];
    bank_e         sel_q;

    assign comp_in[C_Y]  = y_in;
    assign comp_in[C_CB] = cb_in;
    assign comp_in[C_CR] = cr_in;

    lb_wr_ctrl #(.LINE_LEN(LINE_LEN), .AW(AW)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .line_start (line_start),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .wr_fire    (wr_fire),
        .line_full  (line_full)
    );

    lb_rd_ctrl #(.LINE_LEN(LINE_LEN), .AW(AW)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .swap        (line_start),
        .line_full   (line_full),
        .rd_addr     (rd_addr),
        .rd_active   (rd_active),
        .rd_first    (rd_first),
        .replay_done (replay_done)
    );

    // One memory per bank and per component.
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        for (genvar c = 0; c < NCOMP; c++) begin : g_comp
            lb_bank_ram #(.W(DW), .DEPTH(LINE_LEN), .AW(AW)) u_ram (
                .clk   (clk),
                .we    (wr_fire && (wr_bank == bank_e'(b))),
                .waddr (wr_addr),
                .wdata (comp_in[c]),
                .raddr (rd_addr),
                .rdata (bank_q[b][c])
            );
        end
    end

    // Output stage aligned with the registered memory read.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid      <= 1'b0;
            rd_line_start <= 1'b0;
            sel_q         <= BANK_B;
        end else begin
            rd_valid      <= rd_active;
            rd_line_start <= rd_first;
            sel_q         <= other_bank(wr_bank);
        end
    end

    assign y_out  = bank_q[sel_q][C_Y];
    assign cb_out = bank_q[sel_q][C_CB];
    assign cr_out = bank_q[sel_q][C_CR];

    p_valid_follows_r4: assert property (@(posedge clk) disable iff (rst)
        rd_active |=> rd_valid);

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !rd_active |=> !rd_valid);

    p_mark_in_valid_r6: assert property (@(posedge clk) disable iff (rst)
        rd_line_start |-> rd_valid);

    p_read_other_r9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (sel_q != wr_bank) || $past(line_start));

endmodule

// File: tb/line_doubler_tb.sv
module line_doubler_tb_top;

    localparam int DW   = 8;
    localparam int LEN  = 720;
    localparam int IW   = 3 * DW + 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic          line_start;
    logic [DW-1:0] y_in, cb_in, cr_in;
    logic          rd_valid, rd_line_start, replay_done;
    logic [DW-1:0] y_out, cb_out, cr_out;

    always #2 clk = ~clk;   // 250 MHz

    line_doubler #(.DW(DW), .LINE_LEN(LEN)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .line_start    (line_start),
        .y_in          (y_in),
        .cb_in         (cb_in),
        .cr_in         (cr_in),
        .rd_valid      (rd_valid),
        .rd_line_start (rd_line_start),
        .y_out         (y_out),
        .cb_out        (cb_out),
        .cr_out        (cr_out),
        .replay_done   (replay_done)
    );

    // Reference model: the line being captured and the expected output queue.
    // Queue item: {mark, last, y, cb, cr}
    logic [3*DW-1:0] cap [LEN];
    int              cap_cnt;
    logic [IW-1:0]   exp_q [$];
    logic            exp_done;
    int              vectors = 0;
    int              miscompares = 0;
    string           req = "R1";
    bit              finished = 0;

    function automatic logic [3*DW-1:0] pix(input int ln, input int i);
        logic [DW-1:0] y, cb, cr;
        y  = DW'(i * 7 + ln * 31);
        cb = DW'(i * 3 + ln * 5 + 17);
        cr = DW'(255 - i + ln * 11);
        return {y, cb, cr};
    endfunction

    task automatic fail(input string what, input logic [31:0] act, input logic [31:0] exp);
        miscompares++;
        $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    endtask

    // One clock: drive inputs, let the edge pass, compare, update the model.
    task automatic step(input logic r, input logic we, input logic ls, input logic [3*DW-1:0] d);
        logic [IW-1:0] item;
        logic          has;
        logic          e_valid, e_mark;
        logic [3*DW-1:0] e_data;
        @(negedge clk);
        rst = r; wr_en = we; line_start = ls;
        {y_in, cb_in, cr_in} = d;
        @(posedge clk);
        #1;
        has = 1'b0; item = '0;
        if (r) begin
            exp_q.delete();
            exp_done = 1'b0;
        end else if (exp_q.size() > 0) begin
            item = exp_q.pop_front();
            has  = 1'b1;
            if (item[IW-2] && !ls) exp_done = 1'b1;
        end
        e_valid = has;
        e_mark  = has && item[IW-1];
        e_data  = item[3*DW-1:0];
        vectors++;
        if (rd_valid !== e_valid) fail("rd_valid", 32'(rd_valid), 32'(e_valid));
        else if (e_valid && (rd_line_start !== e_mark)) fail("rd_line_start R6", 32'(rd_line_start), 32'(e_mark));
        else if (!e_valid && (rd_line_start !== 1'b0)) fail("rd_line_start R6", 32'(rd_line_start), 32'd0);
        else if (e_valid && ({y_out, cb_out, cr_out} !== e_data)) fail("data R5", 32'({y_out, cb_out, cr_out}), 32'(e_data));
        // The done flag is judged before this edge's swap clears it in the model.
        if (replay_done !== (exp_done && !ls)) fail("replay_done R7", 32'(replay_done), 32'(exp_done && !ls));
        if (r) begin
            cap_cnt = 0;
        end else if (ls) begin
            exp_done = 1'b0;
            exp_q.delete();
            if (cap_cnt >= LEN) begin
                for (int p = 0; p < 2; p++)
                    for (int i = 0; i < LEN; i++)
                        exp_q.push_back({(i == 0), (p == 1 && i == LEN - 1), cap[i]});
            end
            cap_cnt = 0;
        end else if (we) begin
            if (cap_cnt < LEN) cap[cap_cnt] = d;
            cap_cnt++;
        end
    endtask

    // A line period: n_samples strobes every `gap` cycles, padded to `period`.
    task automatic line(input int ln, input int n_samples, input int gap, input int period);
        int s = 0;
        for (int c = 0; c < period; c++) begin
            if ((c % gap == 0) && (s < n_samples)) begin
                step(1'b0, 1'b1, 1'b0, pix(ln, s));
                s++;
            end else begin
                step(1'b0, 1'b0, 1'b0, '0);
            end
        end
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; line_start = 1'b0;
        y_in = '0; cb_in = '0; cr_in = '0;
        exp_done = 1'b0; cap_cnt = 0;

        // R1: reset state, and quiet outputs after release
        req = "R1";
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, '0);
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0, '0);

        // R8: swap with an empty line starts nothing
        req = "R8";
        step(1'b0, 1'b0, 1'b1, '0);
        line(1, 0, 2, 30);

        // R2: full line at half rate plus ten surplus strobes
        req = "R2";
        line(2, LEN + 10, 2, 1716);

        // R3/R4: swap with a coinciding strobe, replay of line 2
        req = "R3";
        step(1'b0, 1'b1, 1'b1, pix(99, 0));
        // R9/R5/R6/R7: line 3 fills while line 2 replays twice
        req = "R9";
        line(3, LEN, 2, 1715);
        req = "R4";
        step(1'b0, 1'b0, 1'b1, '0);
        // R8: short line closed after line 3 replay has finished
        req = "R5";
        line(4, 300, 2, 1715);
        req = "R8";
        step(1'b0, 1'b0, 1'b1, '0);
        line(5, LEN, 2, 1500);
        req = "R7";
        step(1'b0, 1'b0, 1'b1, '0);
        // R10: next line arrives at full rate and cuts the replay short
        req = "R10";
        line(6, LEN, 1, 730);
        step(1'b0, 1'b0, 1'b1, '0);
        // R10: a short line then aborts with no new replay
        line(7, 100, 1, 400);
        step(1'b0, 1'b0, 1'b1, '0);
        line(8, LEN, 1, 800);
        req = "R6";
        step(1'b0, 1'b0, 1'b1, '0);
        line(9, 0, 2, 1600);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog %s: actual hung expected finished", req);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule